// File: doc/BRIEF.md
# Ethernet Transmit Outcome and Abort Controller

This block sits beside a MAC transmit path and turns the per-frame events that path reports into one read-only outcome word. It counts collisions and deferrals from the start of each frame. It reacts to FIFO underruns. When a frame ends it checks the frame length and the CRC verdict against the configuration. From these results it decides whether the frame is aborted.

An abort of any kind sets the matching outcome bit and raises a transmit-error interrupt flag with a one-cycle pulse. It also holds a halt output that freezes further frame processing. Software releases the halt by writing 1 to the interrupt clear input. For an oversize frame the block also asks the datapath to truncate, and it reports a length of zero for the descriptor writeback.

Top module: `eth_tx_outcome`

## Requirements
- R1: After reset the outcome word, halt, interrupt flag, interrupt pulse, truncate and writeback strobe are all 0.
- R2: Collisions, both normal and late, are counted from zero at each accepted frame start. The count saturates at its maximum. When the count exceeds the retry limit (strictly greater), bit 10 of the outcome word is set one cycle after the collision strobe.
- R3: A FIFO underrun strobe sets bit 9 one cycle later.
- R4: At frame end, with jumbo_allow = 0 and frame_len > max_len, the block sets bit 8 and raises truncate. It reports wb_len = 0 in the writeback that appears one cycle after frame_end.
- R5: With jumbo_allow = 1, an oversize frame causes no abort, and the writeback reports the real length.
- R6: Bit 6 (deferred) holds 1 when the frame's deferral count is at least 1 and below defer_limit. Deferral strobes and normal collision strobes both add to this count. Late collisions never add to it.
- R7: At frame end, crc_ok = 0 sets bit 5 only while crc_insert = 0. With crc_insert = 1 the CRC verdict is ignored.
- R8: Any abort (bits 10, 9, 8 or 5) sets halt and irq_flag one cycle later and gives a single one-cycle irq_pulse. When several aborts occur in the same cycle, every matching bit is set and only one pulse is issued.
- R9: While halt is 1, every event strobe and frame start is ignored, and the outcome word stays unchanged. irq_clr = 1 drops halt and irq_flag on the next cycle.
- R10: An accepted frame_start clears the outcome word, the counters and truncate. Bits 7, 4..0 always read 0. A frame end that is accepted gives one wb_valid pulse carrying frame_len (or 0 per R4) one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | A new frame begins |
| coll_evt | input | 1 | Normal collision strobe |
| late_coll_evt | input | 1 | Late collision strobe |
| defer_evt | input | 1 | Deferral strobe |
| underrun_evt | input | 1 | Transmit FIFO underrun strobe |
| frame_end | input | 1 | Frame finished; length and CRC verdict valid |
| frame_len | input | LW | Length of the finished frame |
| crc_ok | input | 1 | Appended CRC matched the computed one |
| retry_limit | input | CW | Collision retry limit |
| defer_limit | input | DW | Excessive deferral limit |
| max_len | input | LW | Maximum frame length |
| jumbo_allow | input | 1 | 1 allows frames longer than max_len |
| crc_insert | input | 1 | 1 when the MAC inserts the CRC itself |
| irq_clr | input | 1 | Write-1 clear of the error flag and halt |
| status | output | 11 | Outcome word |
| irq_flag | output | 1 | Transmit error interrupt flag |
| irq_pulse | output | 1 | One-cycle pulse when an error is raised |
| halt | output | 1 | Stops further frame processing |
| truncate | output | 1 | Truncate request for an oversize frame |
| wb_valid | output | 1 | Descriptor writeback strobe |
| wb_len | output | LW | Length written back to the descriptor |

## Verification
On every cycle the assertions check several properties. An abort always leads to halt, and halt persists until cleared. The interrupt pulse never lasts two cycles. The outcome word is frozen while halted. A CRC error bit never rises while CRC insertion is on. Counters restart at a frame start, and a truncated writeback reports zero length. Other behaviour can only be shown by the bench's scenarios: the strict retry comparison at its boundary, the deferral window and its exclusion of late collisions, configuration-dependent suppression, several aborts merging into one pulse, and the exact lengths written back.

// File: rtl/eth_txo_pkg.sv
package eth_txo_pkg;
  localparam int ST_W        = 11;
  localparam int BIT_EXCOLL  = 10;
  localparam int BIT_UNDRUN  = 9;
  localparam int BIT_OVERSZ  = 8;
  localparam int BIT_DEFER   = 6;
  localparam int BIT_CRCERR  = 5;

  typedef struct packed {
    logic excoll;
    logic undrun;
    logic oversz;
    logic crcerr;
  } abort_t;
endpackage

// File: rtl/txo_rst_sync.sv
module txo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/txo_event_counters.sv
module txo_event_counters #(
  parameter int CW = 5,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clr,
  input  logic          coll,
  input  logic          late_coll,
  input  logic          defer,
  input  logic [CW-1:0] retry_limit,
  input  logic [DW-1:0] defer_limit,
  output logic          coll_over,
  output logic          defer_upd,
  output logic          defer_val
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  localparam logic [DW-1:0] DMAX = {DW{1'b1}};

  logic [CW-1:0] coll_q, coll_d, coll_base;
  logic [DW-1:0] dfr_q, dfr_d, dfr_base;
  logic          coll_any, dfr_any, coll_we, dfr_we;

  always_comb begin
    coll_base = clr ? '0 : coll_q;
    dfr_base  = clr ? '0 : dfr_q;
    coll_any  = en && (coll || late_coll);
    dfr_any   = en && (defer || coll);
    coll_d    = coll_base;
    if (coll_any && (coll_base != CMAX)) coll_d = coll_base + 1'b1;
    dfr_d     = dfr_base;
    if (dfr_any && (dfr_base != DMAX)) dfr_d = dfr_base + 1'b1;
    coll_we   = clr || coll_any;
    dfr_we    = clr || dfr_any;
    coll_over = coll_any && (coll_d > retry_limit);
    defer_upd = dfr_any;
    defer_val = (dfr_d != '0) && (dfr_d < defer_limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coll_q <= '0;
      dfr_q  <= '0;
    end else begin
      if (coll_we) coll_q <= coll_d;
      if (dfr_we)  dfr_q  <= dfr_d;
    end
  end

  AST_COLL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (coll_q < 2)); // R2
  AST_DEFER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (dfr_q < 2)); // R6
endmodule

// File: rtl/txo_frame_end.sv
module txo_frame_end #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          frame_end,
  input  logic [LW-1:0] frame_len,
  input  logic          crc_ok,
  input  logic [LW-1:0] max_len,
  input  logic          jumbo_allow,
  input  logic          crc_insert,
  output logic          oversize,
  output logic          crc_bad,
  output logic          wb_valid,
  output logic [LW-1:0] wb_len
);
  logic          end_ok;
  logic          wbv_d;
  logic [LW-1:0] wbl_d;

  always_comb begin
    end_ok   = en && frame_end;
    oversize = end_ok && !jumbo_allow && (frame_len > max_len);
    crc_bad  = end_ok && !crc_insert && !crc_ok;
    wbv_d    = end_ok;
    wbl_d    = oversize ? '0 : frame_len;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_len   <= '0;
    end else begin
      wb_valid <= wbv_d;
      if (end_ok) wb_len <= wbl_d;
    end
  end

  AST_WB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !$past(frame_end)) |-> 1'b0); // R10
endmodule

// File: rtl/txo_abort_ctrl.sv
module txo_abort_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic abort_any,
  input  logic irq_clr,
  output logic halted,
  output logic irq_pulse
);
  logic flag_q, flag_d, pulse_d;

  always_comb begin
    flag_d = flag_q;
    if (irq_clr)   flag_d = 1'b0;
    if (abort_any) flag_d = 1'b1;
    pulse_d = abort_any && !flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q    <= 1'b0;
      irq_pulse <= 1'b0;
    end else begin
      flag_q    <= flag_d;
      irq_pulse <= pulse_d;
    end
  end

  assign halted = flag_q;

  AST_ABORT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    abort_any |=> halted); // R8
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse); // R8
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !irq_clr) |=> halted); // R9
endmodule

// File: rtl/eth_tx_outcome.sv
module eth_tx_outcome
  import eth_txo_pkg::*;
#(
  parameter int CW = 5,
  parameter int DW = 4,
  parameter int LW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_start,
  input  logic            coll_evt,
  input  logic            late_coll_evt,
  input  logic            defer_evt,
  input  logic            underrun_evt,
  input  logic            frame_end,
  input  logic [LW-1:0]   frame_len,
  input  logic            crc_ok,
  input  logic [CW-1:0]   retry_limit,
  input  logic [DW-1:0]   defer_limit,
  input  logic [LW-1:0]   max_len,
  input  logic            jumbo_allow,
  input  logic            crc_insert,
  input  logic            irq_clr,
  output logic [ST_W-1:0] status,
  output logic            irq_flag,
  output logic            irq_pulse,
  output logic            halt,
  output logic            truncate,
  output logic            wb_valid,
  output logic [LW-1:0]   wb_len
);
  logic            rst_ns;
  logic            en, start_ok;
  logic            coll_over, defer_upd, defer_val;
  logic            oversize, crc_bad;
  abort_t          ab;
  logic            abort_any;
  logic [ST_W-1:0] st_q, st_d;
  logic            trunc_q, trunc_d;

  txo_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ns(rst_ns)
  );

  assign en       = !halt;
  assign start_ok = en && frame_start;

  txo_event_counters #(.CW(CW), .DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_ns), .en(en), .clr(start_ok),
    .coll(coll_evt), .late_coll(late_coll_evt), .defer(defer_evt),
    .retry_limit(retry_limit), .defer_limit(defer_limit),
    .coll_over(coll_over), .defer_upd(defer_upd), .defer_val(defer_val)
  );

  txo_frame_end #(.LW(LW)) u_end (
    .clk(clk), .rst_n(rst_ns), .en(en), .frame_end(frame_end),
    .frame_len(frame_len), .crc_ok(crc_ok), .max_len(max_len),
    .jumbo_allow(jumbo_allow), .crc_insert(crc_insert),
    .oversize(oversize), .crc_bad(crc_bad),
    .wb_valid(wb_valid), .wb_len(wb_len)
  );

  always_comb begin
    ab.excoll = coll_over;
    ab.undrun = en && underrun_evt;
    ab.oversz = oversize;
    ab.crcerr = crc_bad;
    abort_any = |ab;
  end

  txo_abort_ctrl u_abt (
    .clk(clk), .rst_n(rst_ns), .abort_any(abort_any), .irq_clr(irq_clr),
    .halted(halt), .irq_pulse(irq_pulse)
  );

  always_comb begin
    st_d    = st_q;
    trunc_d = trunc_q;
    if (start_ok) begin
      st_d    = '0;
      trunc_d = 1'b0;
    end
    if (ab.excoll) st_d[BIT_EXCOLL] = 1'b1;
    if (ab.undrun) st_d[BIT_UNDRUN] = 1'b1;
    if (ab.crcerr) st_d[BIT_CRCERR] = 1'b1;
    if (ab.oversz) begin
      st_d[BIT_OVERSZ] = 1'b1;
      trunc_d          = 1'b1;
    end
    if (defer_upd) st_d[BIT_DEFER] = defer_val;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st_q    <= '0;
      trunc_q <= 1'b0;
    end else if (en) begin
      st_q    <= st_d;
      trunc_q <= trunc_d;
    end
  end

  assign status   = st_q;
  assign truncate = trunc_q;
  assign irq_flag = halt;

  AST_FROZEN_HALTED: assert property (@(posedge clk) disable iff (!rst_ns)
    $past(halt) |-> $stable(status)); // R9
  AST_CRC_SUPPRESSED: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(status[BIT_CRCERR]) |-> $past(!crc_insert)); // R7
  AST_TRUNC_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_ns)
    (wb_valid && truncate) |-> (wb_len == '0)); // R4
  AST_UNDERRUN_SETS: assert property (@(posedge clk) disable iff (!rst_ns)
    (underrun_evt && !halt) |=> status[BIT_UNDRUN]); // R3
endmodule

// File: tb/eth_tx_outcome_test.sv
module eth_tx_outcome_test;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic frame_start, coll_evt, late_coll_evt, defer_evt, underrun_evt, frame_end;
  logic [LW-1:0] frame_len, max_len;
  logic crc_ok, jumbo_allow, crc_insert, irq_clr;
  logic [4:0] retry_limit;
  logic [3:0] defer_limit;
  logic [10:0] status;
  logic irq_flag, irq_pulse, halt, truncate, wb_valid;
  logic [LW-1:0] wb_len;

  int n_chk = 0;
  int n_fail = 0;
  int pulse_cnt = 0;
  int exp_pulses = 0;
  bit done = 1'b0;
  int exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  eth_tx_outcome uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .coll_evt(coll_evt),
    .late_coll_evt(late_coll_evt), .defer_evt(defer_evt), .underrun_evt(underrun_evt),
    .frame_end(frame_end), .frame_len(frame_len), .crc_ok(crc_ok),
    .retry_limit(retry_limit), .defer_limit(defer_limit), .max_len(max_len),
    .jumbo_allow(jumbo_allow), .crc_insert(crc_insert), .irq_clr(irq_clr),
    .status(status), .irq_flag(irq_flag), .irq_pulse(irq_pulse), .halt(halt),
    .truncate(truncate), .wb_valid(wb_valid), .wb_len(wb_len)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: one cycle of strobes, returns at the negedge after the capturing edge
  task automatic fire(input bit s, input bit c, input bit l, input bit d,
                      input bit u, input bit e, input int len, input bit ok);
    frame_start = s; coll_evt = c; late_coll_evt = l; defer_evt = d;
    underrun_evt = u; frame_end = e; frame_len = len[LW-1:0]; crc_ok = ok;
    @(negedge clk);
    frame_start = 0; coll_evt = 0; late_coll_evt = 0; defer_evt = 0;
    underrun_evt = 0; frame_end = 0;
  endtask

  task automatic start();             fire(1,0,0,0,0,0,0,1); endtask
  task automatic coll();              fire(0,1,0,0,0,0,0,1); endtask
  task automatic defer();             fire(0,0,0,1,0,0,0,1); endtask
  task automatic fend(input int len, input bit ok, input int exp_len);
    exp_q.push_back(exp_len);
    fire(0,0,0,0,0,1,len,ok);
  endtask

  task automatic clear_irq();
    irq_clr = 1; @(negedge clk); irq_clr = 0;
  endtask

  // monitor: scoreboard of writebacks and interrupt pulses
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_pulse) pulse_cnt++;
      if (wb_valid) begin
        if (exp_q.size() == 0) check("R10 unexpected writeback", 1, 0);
        else check("R10/R4 writeback length", wb_len, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; frame_start = 0; coll_evt = 0; late_coll_evt = 0; defer_evt = 0;
    underrun_evt = 0; frame_end = 0; frame_len = 0; crc_ok = 1; irq_clr = 0;
    retry_limit = 5'd3; defer_limit = 4'd4; max_len = 16'd100;
    jumbo_allow = 0; crc_insert = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 status", status, 0);
    check("R1 halt/irq/pulse/trunc/wb", {halt, irq_flag, irq_pulse, truncate, wb_valid}, 0);

    // frame A: one deferral
    start(); defer();
    check("R6 single deferral", status, 11'h040);
    fend(60, 1, 60);
    // frame B: start clears, 3 collisions within retry limit
    start();
    check("R10 start clears status", status, 0);
    coll(); coll(); coll();
    check("R2 three collisions no abort", status, 11'h040);
    fend(64, 1, 64);
    // frame C: late collision only
    start(); fire(0,0,1,0,0,0,0,1);
    check("R6 late collision not deferred", status, 0);
    // frame D: deferrals reach limit
    start(); defer(); defer(); defer(); defer();
    check("R6 excessive deferral clears bit", status, 0);
    // frame E: counters restart; 4th collision exceeds 3
    start(); coll(); coll(); coll();
    check("R2 count restarted per frame", {halt, status}, {1'b0, 11'h040});
    coll(); exp_pulses++;
    check("R2 excess collisions", status, 11'h400);
    check("R8 halt and flag", {halt, irq_flag}, 2'b11);
    // halted: everything ignored
    fire(0,0,0,0,1,0,0,1);
    check("R9 underrun ignored", status, 11'h400);
    start();
    check("R9 start ignored", status, 11'h400);
    fire(0,0,0,0,0,1,90,1);
    check("R9 end ignored", status, 11'h400);
    clear_irq();
    check("R9 clear releases", {halt, irq_flag, status}, {2'b00, 11'h400});
    // frame F: underrun
    start(); fire(0,0,0,0,1,0,0,1); exp_pulses++;
    check("R3 underrun", {halt, status}, {1'b1, 11'h200});
    clear_irq();
    // frame G: oversize
    start(); fend(150, 1, 0); exp_pulses++;
    check("R4 oversize abort", {truncate, halt, status}, {2'b11, 11'h100});
    clear_irq(); start();
    check("R10 start clears truncate", truncate, 0);
    // frame H: jumbo allowed
    jumbo_allow = 1;
    fend(150, 1, 150);
    check("R5 jumbo allowed", {truncate, halt, status}, {2'b00, 11'h000});
    jumbo_allow = 0;
    // frame I: CRC mismatch
    start(); fend(80, 0, 80); exp_pulses++;
    check("R7 crc error", {halt, status}, {1'b1, 11'h020});
    clear_irq();
    // frame J: CRC insertion suppresses
    crc_insert = 1;
    start(); fend(80, 0, 80);
    check("R7 crc suppressed", {halt, status}, {1'b0, 11'h000});
    crc_insert = 0;
    // frame K: three aborts at once
    start();
    exp_q.push_back(0);
    fire(0,0,0,0,1,1,150,0); exp_pulses++;
    check("R8 merged aborts", status, 11'h320);
    repeat (3) @(negedge clk);
    check("R8 single pulse per abort event", pulse_cnt, exp_pulses);
    clear_irq();
    // frame L: retry limit 0, first collision aborts
    retry_limit = 5'd0;
    start(); coll(); exp_pulses++;
    check("R2 strict compare at zero", status, 11'h440);
    clear_irq();
    repeat (3) @(negedge clk);
    check("R8 pulse total", pulse_cnt, exp_pulses);
    check("R10 all writebacks seen", exp_q.size(), 0);
    check("R10 bit 7 reads 0", status[7], 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule